// File: doc/BRIEF.md
# Asynchronous Serial Frame Transmitter

This block drives one NRZ serial line from a system clock. A bit-timing generator divides the system clock by 32 times a 13-bit divisor. A formatter turns a data word into a 10-bit or 11-bit frame. It can also build a frame of all ones (line idle) or a frame of all zeros (line break) when asked.

Software-style configuration inputs set the following:
- the divisor;
- the frame length;
- parity on or off;
- parity sense.

Data words enter through a valid/ready handshake. Idle and break frames are requested with single-cycle pulses. These pulses are remembered until the line can serve them.

The block reports activity on `busy`. It gives a one-cycle `done` pulse when the last bit period of a frame has ended.

Top module: `sertx_top`

## Requirements
- R1: A data frame is sent as bit 0 first. It starts with a start bit of 0, then the data bits least-significant first, and ends with a stop bit of 1.
- R2: Every serial bit, including the start bit, stays on `txd` for exactly 32 × divisor system clock cycles. A whole frame of N bits takes N × 32 × divisor cycles from acceptance to `done`.
- R3: While `cfg_div` is zero, no frame starts, `tx_ready` is 0 and `txd` stays 1. A pending data word, idle request or break request starts once the divisor becomes non-zero.
- R4: With `cfg_long`=0 the frame is 10 bits. With `cfg_par_en`=0 it carries data bits 7..0. With `cfg_par_en`=1 it carries data bits 6..0 and then a parity bit. Unused upper data bits are ignored.
- R5: With `cfg_long`=1 the frame is 11 bits. With `cfg_par_en`=0 it carries data bits 8..0. With `cfg_par_en`=1 it carries data bits 7..0 and then a parity bit.
- R6: The parity bit makes the number of ones over the sent data bits plus parity even when `cfg_par_odd`=0, and odd when `cfg_par_odd`=1.
- R7: An idle request produces a frame of ones as long as the configured frame length, with no start bit. `busy` is high throughout and `done` pulses at its end.
- R8: A break request produces a frame of zeros as long as the configured frame length, with no stop bit.
- R9: The divisor is captured when a frame starts. Changing `cfg_div` during a frame does not change that frame's bit timing.
- R10: `txd` is 1 whenever no frame is active. `tx_ready` is high only when the transmitter is idle, so a word is never accepted during a frame.
- R11: `done` is high for exactly one cycle, on the cycle after the final bit period ends. At that same point `txd` returns to 1 and `busy` falls.
- R12: When several requests wait together, a break frame is sent first, then an idle frame, then the data word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_div | input | 13 | Bit-timing divisor; zero stops the generator |
| cfg_long | input | 1 | 0: 10-bit frames, 1: 11-bit frames |
| cfg_par_en | input | 1 | Replace the top data bit with a parity bit |
| cfg_par_odd | input | 1 | 0: even parity, 1: odd parity |
| idle_req | input | 1 | One-cycle pulse requesting an all-ones frame |
| brk_req | input | 1 | One-cycle pulse requesting an all-zeros frame |
| tx_data | input | 9 | Data word, bit 0 sent first |
| tx_valid | input | 1 | Data word offered |
| tx_ready | output | 1 | Data word taken on this edge when valid |
| txd | output | 1 | Serial line |
| busy | output | 1 | A frame is on the line |
| done | output | 1 | One-cycle pulse at the end of a frame |

## Verification
The edge that accepts a word or request is the edge that puts bit 0 on `txd`. Bit i of a frame therefore occupies edges E0 + i·P up to E0 + (i+1)·P − 1, where P = 32 × divisor. The checks sample each bit halfway through that window, one time unit after an edge. Exact timing is checked in two ways: the start bit is observed on the last cycle before the boundary and the first data bit on the first cycle after it. `done` is expected on edge E0 + N·P and nowhere else. A queued next frame starts on the following edge, so back-to-back frames are checked by counting on from that edge.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  typedef enum logic [1:0] {
    FK_DATA  = 2'd0,
    FK_IDLE  = 2'd1,
    FK_BREAK = 2'd2
  } frame_kind_e;

  localparam int FRAME_MAX = 11;
  localparam int FRAME_MIN = 10;
  localparam int IDX_W     = $clog2(FRAME_MAX + 1);

endpackage

// File: rtl/sertx_baud.sv
module sertx_baud #(
  parameter int DIV_W = 13,
  parameter int PRE_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             run,
  input  logic [DIV_W-1:0] div_in,
  output logic             tick
);
  localparam logic [PRE_W-1:0] PRE_LAST = {PRE_W{1'b1}};

  logic [DIV_W-1:0] div_l;
  logic [DIV_W-1:0] mod_cnt;
  logic [PRE_W-1:0] pre_cnt;
  logic [DIV_W-1:0] mod_last;

  assign mod_last = div_l - 1'b1;
  assign tick     = run && (pre_cnt == PRE_LAST) && (mod_cnt == mod_last);

  always_ff @(posedge clk) begin
    if (rst) begin
      div_l   <= '0;
      pre_cnt <= '0;
      mod_cnt <= '0;
    end else if (load) begin
      div_l   <= div_in;
      pre_cnt <= '0;
      mod_cnt <= '0;
    end else if (run) begin
      if (pre_cnt == PRE_LAST) begin
        pre_cnt <= '0;
        mod_cnt <= (mod_cnt == mod_last) ? '0 : mod_cnt + 1'b1;
      end else begin
        pre_cnt <= pre_cnt + 1'b1;
      end
    end
  end

  // R3: a running frame always works from a non-zero captured divisor
  p_div_nonzero_r3: assert property (@(posedge clk) disable iff (rst)
    run |-> (div_l != '0));

  // R9: captured divisor never moves while a frame runs
  p_div_locked_r9: assert property (@(posedge clk) disable iff (rst)
    (run && $past(run)) |-> $stable(div_l));

endmodule

// File: rtl/sertx_fmt.sv
module sertx_fmt
  import sertx_pkg::*;
#(
  parameter int DATA_W = 9
) (
  input  frame_kind_e       kind,
  input  logic              lng,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic [DATA_W-1:0] data,
  output logic [FRAME_MAX-1:0] frame,
  output logic [IDX_W-1:0]  nbits
);
  logic par7;
  logic par8;

  assign par7 = (^data[6:0]) ^ par_odd;
  assign par8 = (^data[7:0]) ^ par_odd;

  always_comb begin
    nbits = lng ? IDX_W'(FRAME_MAX) : IDX_W'(FRAME_MIN);
    unique case ({lng, par_en})
      2'b00:   frame = {1'b1, 1'b1, data[7:0], 1'b0};
      2'b01:   frame = {1'b1, 1'b1, par7, data[6:0], 1'b0};
      2'b10:   frame = {1'b1, data[8:0], 1'b0};
      default: frame = {1'b1, par8, data[7:0], 1'b0};
    endcase
    if (kind == FK_IDLE)  frame = '1;
    if (kind == FK_BREAK) frame = '0;
  end

endmodule

// File: rtl/sertx_ctl.sv
module sertx_ctl
  import sertx_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 div_nz,
  input  logic                 tx_valid,
  input  logic                 idle_req,
  input  logic                 brk_req,
  input  logic                 tick,
  input  logic [FRAME_MAX-1:0] frame,
  input  logic [IDX_W-1:0]     nbits,
  output frame_kind_e          kind,
  output logic                 start,
  output logic                 tx_ready,
  output logic                 txd,
  output logic                 busy,
  output logic                 done
);
  logic                 run;
  logic                 brk_p;
  logic                 idle_p;
  logic [FRAME_MAX-1:0] sh;
  logic [IDX_W-1:0]     idx;
  logic [IDX_W-1:0]     nb;

  always_comb begin
    if (brk_p)       kind = FK_BREAK;
    else if (idle_p) kind = FK_IDLE;
    else             kind = FK_DATA;
  end

  assign start    = !run && div_nz && (brk_p || idle_p || tx_valid);
  assign tx_ready = !run && div_nz && !brk_p && !idle_p;
  assign busy     = run;

  always_ff @(posedge clk) begin
    if (rst) begin
      run    <= 1'b0;
      brk_p  <= 1'b0;
      idle_p <= 1'b0;
      sh     <= '1;
      idx    <= '0;
      nb     <= '0;
      txd    <= 1'b1;
      done   <= 1'b0;
    end else begin
      done   <= 1'b0;
      brk_p  <= brk_p | brk_req;
      idle_p <= idle_p | idle_req;
      if (start) begin
        run <= 1'b1;
        sh  <= frame;
        txd <= frame[0];
        idx <= '0;
        nb  <= nbits;
        if (kind == FK_BREAK)     brk_p  <= 1'b0;
        else if (kind == FK_IDLE) idle_p <= 1'b0;
      end else if (run && tick) begin
        if (idx == nb - 1'b1) begin
          run  <= 1'b0;
          txd  <= 1'b1;
          done <= 1'b1;
        end else begin
          idx <= idx + 1'b1;
          sh  <= sh >> 1;
          txd <= sh[1];
        end
      end
    end
  end

  // R10: line rests high outside frames
  p_line_high_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !run |-> txd);

  // R11: done never lasts more than one cycle
  p_done_single_r11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R2: line holds its value between bit-timing ticks
  p_bit_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (run && $past(run) && !$past(tick) && !$past(start)) |-> $stable(txd));

  // R1: a data frame opens with a low start bit
  p_start_low_r1: assert property (@(posedge clk) disable iff (rst)
    (start && kind == FK_DATA) |=> !txd);

endmodule

// File: rtl/sertx_top.sv
module sertx_top
  import sertx_pkg::*;
#(
  parameter int DIV_W  = 13,
  parameter int PRE_W  = 5,
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic              cfg_long,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              idle_req,
  input  logic              brk_req,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic              txd,
  output logic              busy,
  output logic              done
);
  frame_kind_e          kind;
  logic                 start;
  logic                 tick;
  logic [FRAME_MAX-1:0] frame;
  logic [IDX_W-1:0]     nbits;

  sertx_fmt #(.DATA_W(DATA_W)) u_fmt (
    .kind    (kind),
    .lng     (cfg_long),
    .par_en  (cfg_par_en),
    .par_odd (cfg_par_odd),
    .data    (tx_data),
    .frame   (frame),
    .nbits   (nbits)
  );

  sertx_baud #(.DIV_W(DIV_W), .PRE_W(PRE_W)) u_baud (
    .clk    (clk),
    .rst    (rst),
    .load   (start),
    .run    (busy),
    .div_in (cfg_div),
    .tick   (tick)
  );

  sertx_ctl u_ctl (
    .clk      (clk),
    .rst      (rst),
    .div_nz   (cfg_div != '0),
    .tx_valid (tx_valid),
    .idle_req (idle_req),
    .brk_req  (brk_req),
    .tick     (tick),
    .frame    (frame),
    .nbits    (nbits),
    .kind     (kind),
    .start    (start),
    .tx_ready (tx_ready),
    .txd      (txd),
    .busy     (busy),
    .done     (done)
  );

  // R10: the handshake is open only between frames
  p_ready_only_idle_r10: assert property (@(posedge clk) disable iff (rst)
    tx_ready |-> !busy);

endmodule

// File: tb/sim_sertx_top.sv
`timescale 1ns/1ps
module sim_sertx_top;

  logic        clk = 1'b0;
  logic        rst;
  logic [12:0] cfg_div;
  logic        cfg_long, cfg_par_en, cfg_par_odd;
  logic        idle_req, brk_req;
  logic [8:0]  tx_data;
  logic        tx_valid;
  logic        tx_ready, txd, busy, done;

  int total = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  sertx_top u0 (
    .clk(clk), .rst(rst), .cfg_div(cfg_div), .cfg_long(cfg_long),
    .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .idle_req(idle_req), .brk_req(brk_req), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .txd(txd),
    .busy(busy), .done(done)
  );

  typedef struct packed {
    logic        lng;
    logic        pe;
    logic        odd;
    logic [8:0]  d;
    logic [10:0] exp;
    logic [3:0]  n;
  } vec_t;

  // expected frames written bit 0 = first bit on the line
  localparam vec_t VEC [0:7] = '{
    '{1'b0, 1'b0, 1'b0, 9'h0A5, 11'h34A, 4'd10},
    '{1'b0, 1'b1, 1'b0, 9'h005, 11'h20A, 4'd10},
    '{1'b0, 1'b1, 1'b1, 9'h005, 11'h30A, 4'd10},
    '{1'b1, 1'b0, 1'b0, 9'h1C3, 11'h786, 4'd11},
    '{1'b1, 1'b1, 1'b0, 9'h0F0, 11'h5E0, 4'd11},
    '{1'b1, 1'b1, 1'b1, 9'h0F0, 11'h7E0, 4'd11},
    '{1'b1, 1'b1, 1'b0, 9'h007, 11'h60E, 4'd11},
    '{1'b0, 1'b0, 1'b0, 9'h180, 11'h300, 4'd10}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  // Called one time unit after the edge that started the frame.
  task automatic run_frame(input logic [10:0] exp, input int n, input int per,
                           input string req);
    for (int i = 0; i < n; i++) begin
      repeat ((i == 0) ? per / 2 : per) @(posedge clk);
      #1;
      check(txd === exp[i], req, txd, exp[i]);
      if (i == 0) begin
        check(busy === 1'b1 && tx_ready === 1'b0, "R10 busy/ready in frame",
              {busy, tx_ready}, 2'b10);
      end
    end
    repeat (per / 2 - 1) @(posedge clk);
    #1;
    check(done === 1'b0, "R11 done early", done, 1'b0);
    @(posedge clk);
    #1;
    check(done === 1'b1 && txd === 1'b1, "R11 done at end", {done, txd}, 2'b11);
    @(posedge clk);
    #1;
    check(done === 1'b0, "R11 done one cycle", done, 1'b0);
  endtask

  task automatic send(input logic [8:0] d);
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    tx_data  = d;
    tx_valid = 1'b1;
    @(posedge clk);
    #1;
    tx_valid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
  end

  initial begin
    int k;
    rst = 1'b1;
    cfg_div = 13'd1; cfg_long = 1'b0; cfg_par_en = 1'b0; cfg_par_odd = 1'b0;
    idle_req = 1'b0; brk_req = 1'b0; tx_data = '0; tx_valid = 1'b0;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check(txd === 1'b1 && busy === 1'b0 && done === 1'b0 && tx_ready === 1'b1,
          "R10 reset state", {txd, busy, done, tx_ready}, 4'b1001);

    // Vector table: R1 R4 R5 R6 frame layouts at divisor 1
    for (int v = 0; v < 8; v++) begin
      @(negedge clk);
      cfg_long = VEC[v].lng; cfg_par_en = VEC[v].pe; cfg_par_odd = VEC[v].odd;
      send(VEC[v].d);
      run_frame(VEC[v].exp, int'(VEC[v].n), 32, $sformatf("R1/R4/R5/R6 vec %0d", v));
    end

    // R2 and R9: exact bit length at divisor 2, divisor changed mid-frame
    @(negedge clk);
    cfg_long = 1'b0; cfg_par_en = 1'b0; cfg_div = 13'd2;
    send(9'h001);
    cfg_div = 13'd5;
    repeat (63) @(posedge clk);
    #1 check(txd === 1'b0, "R2 start bit held to boundary", txd, 1'b0);
    @(posedge clk);
    #1 check(txd === 1'b1, "R2 first data bit at boundary", txd, 1'b1);
    k = 64;
    while (!done && k < 2000) begin
      @(posedge clk);
      #1 k++;
    end
    check(k == 640, "R9 frame length with divisor changed", k, 640);

    // R3 + R12: everything pending while divisor is zero
    @(negedge clk);
    cfg_div = 13'd0;
    tx_data = 9'h055; tx_valid = 1'b1;
    brk_req = 1'b1; idle_req = 1'b1;
    @(negedge clk);
    brk_req = 1'b0; idle_req = 1'b0;
    repeat (40) @(negedge clk);
    check(txd === 1'b1 && busy === 1'b0 && tx_ready === 1'b0,
          "R3 divisor zero holds line", {txd, busy, tx_ready}, 3'b100);
    cfg_div = 13'd1;
    @(posedge clk);
    #1;
    run_frame(11'h000, 10, 32, "R8 R12 break frame first");
    run_frame(11'h7FF, 10, 32, "R7 R12 idle frame second");
    tx_valid = 1'b0;
    run_frame(11'h2AA, 10, 32, "R12 R3 data frame last");
    repeat (5) @(negedge clk);
    check(busy === 1'b0 && txd === 1'b1, "R10 idle after queue", {busy, txd}, 2'b01);

    // R8: long break frame is 11 bits of zeros
    @(negedge clk);
    cfg_long = 1'b1;
    brk_req = 1'b1;
    @(posedge clk);
    #1 brk_req = 1'b0;
    @(posedge clk);
    #1;
    run_frame(11'h000, 11, 32, "R8 long break");

    summary();
  end

endmodule